// File: doc/BRIEF.md
# Event Ring Producer with Interrupt

This block sits on the device side of a host link. It posts completion and state-change events into a ring that lives in host memory, and it interrupts the host. Three internal sources can raise event requests: state changes, command completions and transfer completions. The block holds its own copies of the ring's read and write pointers. When a slot is free, it stores one event in the element that the read pointer names. It then moves the read pointer forward and raises an interrupt level.

On this ring the producer owns the read pointer. The ring is full when the read pointer equals the write pointer. It holds nothing for the host to service when the write pointer plus one equals the read pointer. The host hands consumed slots back by writing a new write pointer through a doorbell, and that write also drops the interrupt. A source whose request meets a full ring is held off and keeps its request up until the block accepts it. Events are never lost. The memory write is an abstract request/acknowledge port that carries a slot index and the event word.

Top module: `event_ring_producer`

## Requirements
- R1: After reset, irq and memReq are low, no source acknowledge is high, the read pointer is 1 and the write pointer is 0, so the first event goes to slot 1.
- R2: While the read pointer equals the write pointer (ring full), no source is acknowledged. A pending request stays pending, and it is posted once space returns, with no event dropped.
- R3: A posted event is presented with memReq high, memSlot equal to the current read pointer and memData equal to the event word. All three hold steady until the cycle in which memAck is high.
- R4: On each cycle with memReq and memAck both high, the read pointer advances by one, modulo the ring depth.
- R5: Sources are served in fixed priority: state change first, then command completion, then transfer completion. At most one acknowledge is high in a cycle, and it goes only to a requesting source.
- R6: irq goes high in the cycle after a memory acknowledge and stays high until a doorbell write. When a doorbell and a memory acknowledge fall in the same cycle, irq stays high.
- R7: A doorbell write loads dbPtr into the write pointer in the next cycle, which frees slots for requests that are stalled.
- R8: From the empty state (write pointer plus one equals read pointer), exactly DEPTH-1 events can be posted before the ring reads as full.
- R9: The event word is {type code, payload}. The type code is a 2-bit field in the top bits: 1 for a state change, 2 for a command completion, 3 for a transfer completion. The payload is the acknowledged source's data, taken in the acknowledge cycle.
- R10: A source is acknowledged only in a cycle in which no event is waiting on memory, so a new event is accepted at the earliest in the cycle after a memory acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stateReq | input | 1 | State-change event request |
| stateData | input | PAYLOAD_W | State-change payload |
| stateAck | output | 1 | State-change request accepted |
| cmdReq | input | 1 | Command-completion event request |
| cmdData | input | PAYLOAD_W | Command-completion payload |
| cmdAck | output | 1 | Command-completion request accepted |
| xferReq | input | 1 | Transfer-completion event request |
| xferData | input | PAYLOAD_W | Transfer-completion payload |
| xferAck | output | 1 | Transfer-completion request accepted |
| memReq | output | 1 | Event write to host memory pending |
| memSlot | output | PTR_W | Ring slot index to write |
| memData | output | PAYLOAD_W+2 | Event word |
| memAck | input | 1 | Memory write accepted |
| dbWrite | input | 1 | Host doorbell write strobe |
| dbPtr | input | PTR_W | New write pointer from the host |
| irq | output | 1 | Interrupt level toward the host |

## Verification
The hardest situation to reach from the ports is a full ring with several sources still waiting. It only arises after the read pointer has gone all the way round to the write pointer. The stimulus queues more transfer events than the ring can take, withholds the doorbell, confirms that exactly DEPTH-1 get through and that the rest stay pending, then frees the ring through the doorbell. Later phases push all three sources in the same cycle under a slow memory acknowledge, and they line up a doorbell with a memory acknowledge in one cycle so that the interrupt set/clear collision is exercised across a pointer wrap.

// File: rtl/evr_pkg.sv
package evr_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_WRITE = 1'b1
  } evrState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;   // capture event from selected source
    logic [1:0] sel;    // selected source index
    logic       post;   // memory accepted the held event
  } evrStrobe_t;
endpackage

// File: rtl/evr_datapath.sv
module evr_datapath
  import evr_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int PAYLOAD_W = 16,
  parameter int NUM_SRC   = 3,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int TYPE_W   = 2,
  localparam int EVT_W    = TYPE_W + PAYLOAD_W
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  evrStrobe_t                   strobe,
  input  logic [NUM_SRC*PAYLOAD_W-1:0] srcData,
  input  logic                         dbWrite,
  input  logic [PTR_W-1:0]             dbPtr,
  output logic                         full,
  output logic [PTR_W-1:0]             memSlot,
  output logic [EVT_W-1:0]             memData,
  output logic                         irq
);
  logic [PTR_W-1:0] readPtr;
  logic [PTR_W-1:0] writePtr;
  logic [EVT_W-1:0] heldEvt;
  logic [TYPE_W-1:0] typeCode;

  assign typeCode = TYPE_W'(strobe.sel) + TYPE_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readPtr  <= PTR_W'(1);
      writePtr <= '0;
      heldEvt  <= '0;
      irq      <= 1'b0;
    end else begin
      if (strobe.post) readPtr <= readPtr + PTR_W'(1);
      if (dbWrite) writePtr <= dbPtr;
      if (strobe.load)
        heldEvt <= {typeCode, srcData[strobe.sel*PAYLOAD_W +: PAYLOAD_W]};
      if (strobe.post) irq <= 1'b1;
      else if (dbWrite) irq <= 1'b0;
    end
  end

  assign full    = (readPtr == writePtr);
  assign memSlot = readPtr;
  assign memData = heldEvt;

  AST_RP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.post |=> readPtr == $past(readPtr) + PTR_W'(1)); // R4
  AST_IRQ_AFTER_POST: assert property (@(posedge clk) disable iff (!rstN)
    strobe.post |=> irq); // R6
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !dbWrite) |=> irq); // R6
  AST_NO_LOAD_FULL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> readPtr != writePtr); // R2
endmodule

// File: rtl/evr_control.sv
module evr_control
  import evr_pkg::*;
#(
  parameter int NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               full,
  input  logic               memAck,
  output logic [NUM_SRC-1:0] srcAck,
  output logic               memReq,
  output evrStrobe_t         strobe
);
  evrState_e state;
  logic       found;
  logic [1:0] winner;

  // lowest index has highest priority
  always_comb begin
    found  = 1'b0;
    winner = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (srcReq[i]) begin
        found  = 1'b1;
        winner = 2'(i);
      end
    end
  end

  always_comb begin
    srcAck      = '0;
    strobe.load = 1'b0;
    strobe.sel  = winner;
    strobe.post = (state == ST_WRITE) && memAck;
    if (state == ST_IDLE && found && !full) begin
      srcAck[winner] = 1'b1;
      strobe.load    = 1'b1;
    end
  end

  assign memReq = (state == ST_WRITE);

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else begin
      case (state)
        ST_IDLE:  if (strobe.load) state <= ST_WRITE;
        ST_WRITE: if (memAck) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(srcAck)); // R5
  AST_ACK_REQUESTED: assert property (@(posedge clk) disable iff (!rstN)
    (srcAck & ~srcReq) == '0); // R5
  AST_NO_ACK_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (srcAck != '0) |-> !full); // R2
  AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> srcAck == '0); // R10
  AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq); // R3
endmodule

// File: rtl/event_ring_producer.sv
module event_ring_producer
  import evr_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int PAYLOAD_W = 16,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int NUM_SRC  = 3,
  localparam int EVT_W    = PAYLOAD_W + 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 stateReq,
  input  logic [PAYLOAD_W-1:0] stateData,
  output logic                 stateAck,
  input  logic                 cmdReq,
  input  logic [PAYLOAD_W-1:0] cmdData,
  output logic                 cmdAck,
  input  logic                 xferReq,
  input  logic [PAYLOAD_W-1:0] xferData,
  output logic                 xferAck,
  output logic                 memReq,
  output logic [PTR_W-1:0]     memSlot,
  output logic [EVT_W-1:0]     memData,
  input  logic                 memAck,
  input  logic                 dbWrite,
  input  logic [PTR_W-1:0]     dbPtr,
  output logic                 irq
);
  evrStrobe_t         strobe;
  logic               full;
  logic [NUM_SRC-1:0] srcAck;

  evr_control #(.NUM_SRC(NUM_SRC)) i_control (
    .clk    (clk),
    .rstN   (rstN),
    .srcReq ({xferReq, cmdReq, stateReq}),
    .full   (full),
    .memAck (memAck),
    .srcAck (srcAck),
    .memReq (memReq),
    .strobe (strobe)
  );

  evr_datapath #(.DEPTH(DEPTH), .PAYLOAD_W(PAYLOAD_W), .NUM_SRC(NUM_SRC)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .srcData ({xferData, cmdData, stateData}),
    .dbWrite (dbWrite),
    .dbPtr   (dbPtr),
    .full    (full),
    .memSlot (memSlot),
    .memData (memData),
    .irq     (irq)
  );

  assign stateAck = srcAck[0];
  assign cmdAck   = srcAck[1];
  assign xferAck  = srcAck[2];

  AST_SLOT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> $stable(memSlot) && $stable(memData)); // R3
endmodule

// File: tb/test_event_ring_producer.sv
`timescale 1ns/1ps
module test_event_ring_producer;
  localparam int DEPTH = 8;
  localparam int PW    = 16;
  localparam int PTRW  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stateReq = 0, cmdReq = 0, xferReq = 0;
  logic [PW-1:0] stateData = 0, cmdData = 0, xferData = 0;
  logic stateAck, cmdAck, xferAck;
  logic memReq, memAck = 0, dbWrite = 0, irq;
  logic [PTRW-1:0] memSlot, dbPtr = 0;
  logic [PW+1:0] memData;

  event_ring_producer #(.DEPTH(DEPTH), .PAYLOAD_W(PW)) i_event_ring_producer (
    .clk(clk), .rstN(rstN),
    .stateReq(stateReq), .stateData(stateData), .stateAck(stateAck),
    .cmdReq(cmdReq), .cmdData(cmdData), .cmdAck(cmdAck),
    .xferReq(xferReq), .xferData(xferData), .xferAck(xferAck),
    .memReq(memReq), .memSlot(memSlot), .memData(memData), .memAck(memAck),
    .dbWrite(dbWrite), .dbPtr(dbPtr), .irq(irq)
  );

  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;
  logic [PW-1:0] stQ[$], cmQ[$], xfQ[$];
  int postLog[$];
  int mRp = 1, mWp = 0, mHeld = 0;
  bit mBusy = 0, mIrq = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic stepCycle(input bit dbW, input int dbP, input bit ack);
    bit eSt, eCm, eXf, fullNow;
    @(negedge clk);
    stateReq = stQ.size() > 0; if (stateReq) stateData = stQ[0];
    cmdReq   = cmQ.size() > 0; if (cmdReq) cmdData = cmQ[0];
    xferReq  = xfQ.size() > 0; if (xferReq) xferData = xfQ[0];
    memAck = ack; dbWrite = dbW; dbPtr = PTRW'(dbP);
    #1;
    fullNow = (mRp == mWp);
    eSt = !mBusy && !fullNow && stateReq;
    eCm = !mBusy && !fullNow && !stateReq && cmdReq;
    eXf = !mBusy && !fullNow && !stateReq && !cmdReq && xferReq;
    chk(stateAck == eSt, "R5", "stateAck", int'(stateAck), int'(eSt));
    chk(cmdAck == eCm, "R5", "cmdAck", int'(cmdAck), int'(eCm));
    chk(xferAck == eXf, "R2", "xferAck", int'(xferAck), int'(eXf));
    chk(memReq == mBusy, "R10", "memReq", int'(memReq), int'(mBusy));
    chk(irq == mIrq, "R6", "irq", int'(irq), int'(mIrq));
    if (mBusy) begin
      chk(int'(memSlot) == mRp, "R3", "memSlot", int'(memSlot), mRp);
      chk(int'(memData) == mHeld, "R9", "memData", int'(memData), mHeld);
    end
    @(posedge clk);
    if (mBusy && ack) begin
      postLog.push_back(mHeld);
      mRp = (mRp + 1) % DEPTH;
      mBusy = 0;
      mIrq = 1;
    end else begin
      if (dbW) mIrq = 0;
      if (eSt) begin mHeld = (1 << PW) | int'(stQ.pop_front()); mBusy = 1; end
      if (eCm) begin mHeld = (2 << PW) | int'(cmQ.pop_front()); mBusy = 1; end
      if (eXf) begin mHeld = (3 << PW) | int'(xfQ.pop_front()); mBusy = 1; end
    end
    if (dbW) mWp = dbP;
  endtask

  initial begin
    #300000;
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(irq == 0, "R1", "irq in reset", int'(irq), 0);
    chk(memReq == 0, "R1", "memReq in reset", int'(memReq), 0);
    chk({stateAck, cmdAck, xferAck} == 0, "R1", "acks in reset", int'({stateAck, cmdAck, xferAck}), 0);
    @(negedge clk); rstN = 1'b1;

    // phase A: overfill with transfer events, no doorbell
    for (int i = 0; i < 10; i++) xfQ.push_back(PW'(16'h0100 + i));
    for (int c = 0; c < 30; c++) stepCycle(0, 0, 1);
    chk(postLog.size() == DEPTH - 1, "R8", "posted before full", postLog.size(), DEPTH - 1);
    chk(xfQ.size() == 3, "R2", "stalled requests kept", xfQ.size(), 3);
    chk(int'(postLog[0]) == ((3 << PW) | 16'h0100), "R1", "first event", postLog[0], (3 << PW) | 16'h0100);

    // phase B: doorbell frees the ring
    stepCycle(1, (mRp + DEPTH - 1) % DEPTH, 1);
    for (int c = 0; c < 20; c++) stepCycle(0, 0, 1);
    chk(postLog.size() == 10, "R7", "posted after doorbell", postLog.size(), 10);
    chk(xfQ.size() == 0, "R2", "no event dropped", xfQ.size(), 0);

    // phase C: simultaneous sources, slow memory
    stepCycle(1, (mRp + DEPTH - 1) % DEPTH, 0);
    for (int i = 0; i < 2; i++) begin
      xfQ.push_back(PW'(16'h3000 + i));
      cmQ.push_back(PW'(16'h2000 + i));
      stQ.push_back(PW'(16'h1000 + i));
    end
    for (int c = 0; c < 60; c++) stepCycle(0, 0, (c % 3) == 2);
    chk(postLog.size() == 16, "R5", "priority batch count", postLog.size(), 16);
    chk((postLog[10] >> PW) == 1, "R5", "first code state", postLog[10] >> PW, 1);
    chk((postLog[11] >> PW) == 1, "R5", "second code state", postLog[11] >> PW, 1);
    chk((postLog[12] >> PW) == 2, "R9", "third code cmd", postLog[12] >> PW, 2);
    chk((postLog[14] >> PW) == 3, "R9", "fifth code xfer", postLog[14] >> PW, 3);
    chk(postLog[15] == ((3 << PW) | 16'h3001), "R9", "last event", postLog[15], (3 << PW) | 16'h3001);

    // phase D: doorbell together with a memory acknowledge
    cmQ.push_back(16'h2222);
    stepCycle(1, (mRp + DEPTH - 1) % DEPTH, 0);
    while (!mBusy) stepCycle(0, 0, 0);
    stepCycle(1, mRp, 1);
    stepCycle(0, 0, 0);
    chk(irq == 1, "R6", "irq after collision", int'(irq), 1);
    stepCycle(1, (mRp + DEPTH - 1) % DEPTH, 0);
    stepCycle(0, 0, 0);
    chk(irq == 0, "R6", "irq cleared by doorbell", int'(irq), 0);
    chk(postLog.size() == 17, "R4", "total posts", postLog.size(), 17);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule